// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO

This block is a first-in first-out buffer whose writer and reader run on unrelated clocks. Storage is a power-of-two array of `2**ADDR_W` words. Each side keeps a binary pointer with one extra wrap bit. The pointers are exchanged in Gray code through flop synchronisers. Full and empty are decided by comparing a local pointer with the synchronised remote pointer.

A mode input is captured while the master reset is high. The mode decides what the two status pins mean:

- **Standard mode.** `wr_flag` is an active-low full indication and `rd_flag` is an active-low empty indication. A read request loads the next word into the output register on that read-clock edge.
- **Look-ahead mode.** `wr_flag` goes high only when no space is left. `rd_flag` goes low when a word is presented on `rd_data`. The head word moves into the output register without any request. Because of this, the output register adds one word of capacity.

A simple mark-and-replay facility lets the reader read data again. Raising `rt_hold` records the current read position. While `rt_hold` stays high, the writer's space check is made against that recorded position. A pulse on `rt_rewind` then moves reading back to it. The partial reset empties the buffer but keeps the captured mode. The master reset empties it and captures a new mode.

Top module: `dual_mode_fifo`

## Requirements
- R1: In standard mode, after a reset with no reads, `wr_flag` stays high for the first D-1 writes and goes low on the write-clock edge that accepts the D-th write (D = 2**ADDR_W).
- R2: A write presented while the buffer is full is discarded: no stored word changes and the word count does not grow.
- R3: In look-ahead mode, `wr_flag` is low while space remains. Once the first word has reached the output register, `wr_flag` goes high only on the edge accepting the (D+1)-th write with no reads.
- R4: In standard mode, `rd_flag` is low exactly when no word is stored. A read request made while it is low leaves `rd_data` unchanged and consumes nothing.
- R5: In standard mode, each accepted read places the next word on `rd_data` at the read-clock edge that accepts it, and words leave in write order.
- R6: In look-ahead mode, the first word written into an empty buffer appears on `rd_data` with no read request. `rd_flag` goes low in the same read-clock cycle that this word becomes valid.
- R7: In look-ahead mode, `rd_flag` stays low while words remain. It goes high only on a read-clock edge with `rd_en` high when no further word is stored, and `rd_data` keeps the last word.
- R8: While `rt_hold` is high, the full decision uses the read position recorded when `rt_hold` rose, so reads after the mark free no space. When `rt_hold` falls, the live read position is used again.
- R9: A one-cycle pulse on `rt_rewind` while a mark is held moves the read position back to the mark, so the words from the mark onwards are read again in order.
- R10: Either reset empties the buffer and clears both flags to their idle state. The partial reset keeps the captured mode, and the master reset captures `mode_sel` (0 standard, 1 look-ahead).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high, asynchronous; captures `mode_sel` |
| prst | input | 1 | Partial reset, active high, asynchronous; keeps the mode |
| mode_sel | input | 1 | Mode to capture: 0 standard, 1 look-ahead |
| wr_en | input | 1 | Write request (wclk domain) |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read request (rclk domain) |
| rt_hold | input | 1 | Mark level; rising edge records the read position (rclk domain) |
| rt_rewind | input | 1 | Pulse: return the read position to the mark (rclk domain) |
| rd_data | output | DATA_W | Output register |
| wr_flag | output | 1 | Standard: low = full. Look-ahead: high = no space |
| rd_flag | output | 1 | Standard: low = empty. Look-ahead: low = word valid |

## Verification
In look-ahead mode, consuming the presented word and loading the next stored word into the output register happen on the same read-clock edge. The bench provokes this by draining a buffer filled to D+1 words with a read pulse for each word. It checks that every word appears once, in order, with no gap in `rd_flag`. On the write side, a write and a space change seen through the synchroniser can land in the same cycle under an active mark. The bench provokes this by writing until full after reads beyond the mark, and it judges the result by the exact write on which `wr_flag` changes.

// File: rtl/dmfifo_pkg.sv
package dmfifo_pkg;

    typedef enum logic {
        MODE_STD       = 1'b0,
        MODE_LOOKAHEAD = 1'b1
    } fifo_mode_e;

    localparam int DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/dmf_sync.sv
module dmf_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/dmf_ram.sv
module dmf_ram #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/dmf_wr_ctl.sv
module dmf_wr_ctl import dmfifo_pkg::*; #(
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              rst,
    input  logic              mrst,
    input  logic              mode_sel,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   ref_gray_s,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [ADDR_W:0]   wr_gray,
    output logic              wr_flag
);

    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] WRAP_MASK = PW'(3) << (ADDR_W - 1);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          full;
        fifo_mode_e    mode;
    } wr_st_t;

    wr_st_t st_d, st_q;
    logic   accept;

    always_comb begin
        st_d     = st_q;
        accept   = wr_en && !st_q.full;
        st_d.bin = st_q.bin + PW'(accept);
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
        // full: next write pointer is one lap ahead of the reference pointer
        st_d.full = (st_d.gray == (ref_gray_s ^ WRAP_MASK));
    end

    always_ff @(posedge wclk or posedge rst) begin
        if (rst) begin
            st_q.bin  <= '0;
            st_q.gray <= '0;
            st_q.full <= 1'b0;
            if (mrst) st_q.mode <= fifo_mode_e'(mode_sel);
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we    = accept;
    assign mem_waddr = st_q.bin[ADDR_W-1:0];
    assign wr_gray   = st_q.gray;
    assign wr_flag   = (st_q.mode == MODE_LOOKAHEAD) ? st_q.full : !st_q.full;

    AST_WR_BLOCKED_FULL: assert property (@(posedge wclk) disable iff (rst)
        (wr_en && st_q.full) |=> $stable(st_q.bin)); // R2
    AST_WR_IDLE_HOLDS: assert property (@(posedge wclk) disable iff (rst)
        (!wr_en) |=> $stable(st_q.bin)); // R2
    AST_FULL_BY_WRITE: assert property (@(posedge wclk) disable iff (rst)
        $rose(st_q.full) |-> $past(wr_en)); // R1

endmodule

// File: rtl/dmf_rd_ctl.sv
module dmf_rd_ctl import dmfifo_pkg::*; #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              rclk,
    input  logic              rst,
    input  logic              mrst,
    input  logic              mode_sel,
    input  logic              rd_en,
    input  logic              rt_hold,
    input  logic              rt_rewind,
    input  logic [ADDR_W:0]   wr_gray_s,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic [ADDR_W:0]   ref_gray,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_flag
);

    localparam int PW = ADDR_W + 1;

    typedef struct packed {
        logic [PW-1:0]     bin;
        logic              empty;
        logic              valid;
        logic              mark_on;
        logic [PW-1:0]     mark_bin;
        logic [PW-1:0]     ref_gray;
        logic [DATA_W-1:0] dout;
        fifo_mode_e        mode;
    } rd_st_t;

    rd_st_t        st_d, st_q;
    logic          rewind, take, take_ok;
    logic [PW-1:0] ref_bin;

    always_comb begin
        st_d   = st_q;
        rewind = rt_rewind && st_q.mark_on;
        if (st_q.mode == MODE_LOOKAHEAD) take = (!st_q.valid || rd_en) && !st_q.empty;
        else                             take = rd_en && !st_q.empty;
        take_ok = take && !rewind;

        if (rewind) st_d.bin = st_q.mark_bin;
        else        st_d.bin = st_q.bin + PW'(take_ok);

        if (take_ok) st_d.dout = mem_rdata;

        if (rewind)       st_d.valid = 1'b0;
        else if (take_ok) st_d.valid = 1'b1;
        else if (rd_en)   st_d.valid = 1'b0;

        if (!rt_hold) begin
            st_d.mark_on = 1'b0;
        end else if (!st_q.mark_on) begin
            st_d.mark_on  = 1'b1;
            st_d.mark_bin = st_q.bin;
        end

        ref_bin       = st_d.mark_on ? st_d.mark_bin : st_d.bin;
        st_d.ref_gray = ref_bin ^ (ref_bin >> 1);
        st_d.empty    = ((st_d.bin ^ (st_d.bin >> 1)) == wr_gray_s);
    end

    always_ff @(posedge rclk or posedge rst) begin
        if (rst) begin
            st_q.bin      <= '0;
            st_q.empty    <= 1'b1;
            st_q.valid    <= 1'b0;
            st_q.mark_on  <= 1'b0;
            st_q.mark_bin <= '0;
            st_q.ref_gray <= '0;
            st_q.dout     <= '0;
            if (mrst) st_q.mode <= fifo_mode_e'(mode_sel);
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_raddr = st_q.bin[ADDR_W-1:0];
    assign ref_gray  = st_q.ref_gray;
    assign rd_data   = st_q.dout;
    assign rd_flag   = (st_q.mode == MODE_LOOKAHEAD) ? !st_q.valid : !st_q.empty;

    AST_RD_BLOCKED_EMPTY: assert property (@(posedge rclk) disable iff (rst)
        (st_q.mode == MODE_STD && rd_en && st_q.empty && !rt_rewind)
        |=> ($stable(st_q.bin) && $stable(st_q.dout))); // R4
    AST_OUT_HELD: assert property (@(posedge rclk) disable iff (rst)
        (st_q.mode == MODE_LOOKAHEAD && st_q.valid && !rd_en && !rt_rewind)
        |=> (st_q.valid && $stable(st_q.dout))); // R7
    AST_VALID_DROP_NEEDS_READ: assert property (@(posedge rclk) disable iff (rst)
        $fell(st_q.valid) |-> ($past(rd_en) || $past(rt_rewind))); // R7
    AST_MARK_REF_FROZEN: assert property (@(posedge rclk) disable iff (rst)
        (st_q.mark_on && rt_hold) |=> $stable(st_q.ref_gray)); // R8

endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo import dmfifo_pkg::*; #(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              mode_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rt_hold,
    input  logic              rt_rewind,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_flag,
    output logic              rd_flag
);

    localparam int PW = ADDR_W + 1;

    logic              rst;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic [PW-1:0]     wr_gray, wr_gray_s, ref_gray, ref_gray_s;

    assign rst = mrst | prst;

    dmf_wr_ctl #(.ADDR_W(ADDR_W)) i_wr_ctl (
        .wclk       (wclk),
        .rst        (rst),
        .mrst       (mrst),
        .mode_sel   (mode_sel),
        .wr_en      (wr_en),
        .ref_gray_s (ref_gray_s),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .wr_gray    (wr_gray),
        .wr_flag    (wr_flag)
    );

    dmf_rd_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_rd_ctl (
        .rclk       (rclk),
        .rst        (rst),
        .mrst       (mrst),
        .mode_sel   (mode_sel),
        .rd_en      (rd_en),
        .rt_hold    (rt_hold),
        .rt_rewind  (rt_rewind),
        .wr_gray_s  (wr_gray_s),
        .mem_rdata  (mem_rdata),
        .mem_raddr  (mem_raddr),
        .ref_gray   (ref_gray),
        .rd_data    (rd_data),
        .rd_flag    (rd_flag)
    );

    dmf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ram (
        .wclk  (wclk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    dmf_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) i_sync_w2r (
        .clk      (rclk),
        .rst      (rst),
        .async_in (wr_gray),
        .sync_out (wr_gray_s)
    );

    dmf_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) i_sync_r2w (
        .clk      (wclk),
        .rst      (rst),
        .async_in (ref_gray),
        .sync_out (ref_gray_s)
    );

endmodule

// File: tb/test_dual_mode_fifo.sv
module test_dual_mode_fifo;

    localparam int DW = 16;
    localparam int AW = 3;
    localparam int D  = 1 << AW;

    logic          wclk = 1'b0, rclk = 1'b0;
    logic          mrst = 1'b0, prst = 1'b0, mode_sel = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0, rt_hold = 1'b0, rt_rewind = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          wr_flag, rd_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    dual_mode_fifo #(.DATA_W(DW), .ADDR_W(AW)) i_dual_mode_fifo (
        .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .mode_sel(mode_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rt_hold(rt_hold),
        .rt_rewind(rt_rewind), .rd_data(rd_data), .wr_flag(wr_flag), .rd_flag(rd_flag)
    );

    always #10 wclk = ~wclk;
    initial begin
        #7;
        forever #10 rclk = ~rclk;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit master, input bit mode);
        wr_en = 0; rd_en = 0; rt_hold = 0; rt_rewind = 0;
        mode_sel = mode;
        if (master) mrst = 1; else prst = 1;
        repeat (4) @(negedge wclk);
        mrst = 0; prst = 0;
        repeat (4) @(negedge rclk);
    endtask

    task automatic wr1(input logic [DW-1:0] d);
        @(negedge wclk); wr_en = 1; wr_data = d;
        @(negedge wclk); wr_en = 0;
    endtask

    task automatic rd1();
        @(negedge rclk); rd_en = 1;
        @(negedge rclk); rd_en = 0;
    endtask

    task automatic settle();
        repeat (12) @(negedge wclk);
        @(negedge rclk);
    endtask

    task automatic t_reset_std();
        do_reset(1, 0);
        chk("R10 wr_flag idle std", wr_flag, 1);
        chk("R10 rd_flag idle std", rd_flag, 0);
        chk("R10 rd_data cleared", rd_data, 0);
    endtask

    task automatic t_std_fill_drain();
        for (int i = 0; i < D; i++) begin
            wr1(DW'(16'hA0 + i));
            chk("R1 wr_flag during fill", wr_flag, (i == D-1) ? 0 : 1);
        end
        wr1(16'h00EE);
        chk("R2 wr_flag after blocked write", wr_flag, 0);
        settle();
        chk("R4 rd_flag not empty", rd_flag, 1);
        for (int i = 0; i < D; i++) begin
            rd1();
            chk("R5 read order", rd_data, 16'hA0 + i);
            chk("R4 rd_flag during drain", rd_flag, (i == D-1) ? 0 : 1);
        end
        rd1();
        chk("R4 data held on empty read", rd_data, 16'hA0 + D - 1);
        settle();
        chk("R2 no extra word stored", rd_flag, 0);
    endtask

    task automatic t_lookahead();
        int n;
        bit seen;
        do_reset(1, 1);
        chk("R10 wr_flag idle lookahead", wr_flag, 0);
        chk("R10 rd_flag idle lookahead", rd_flag, 1);
        wr1(16'h00C0);
        seen = 0;
        n = 0;
        while (!seen && n < 20) begin
            @(negedge rclk);
            n++;
            if (rd_flag == 1'b0) begin
                seen = 1;
                chk("R6 data valid with flag", rd_data, 16'h00C0);
            end
        end
        chk("R6 word fell through", seen, 1);
        settle();
        for (int i = 1; i <= D; i++) begin
            wr1(DW'(16'hC0 + i));
            chk("R3 wr_flag during fill", wr_flag, (i == D) ? 1 : 0);
        end
        wr1(16'h00EE);
        chk("R3 blocked past D+1", wr_flag, 1);
        settle();
        for (int i = 0; i <= D; i++) begin
            chk("R7 flag low while words remain", rd_flag, 0);
            chk("R7 presented word", rd_data, 16'hC0 + i);
            rd1();
        end
        chk("R7 flag high after last read", rd_flag, 1);
        chk("R7 last word kept", rd_data, 16'hC0 + D);
        rd1();
        chk("R7 extra read no effect", rd_data, 16'hC0 + D);
        settle();
        chk("R2 no overflow word", rd_flag, 1);
    endtask

    task automatic t_reset_modes();
        wr1(16'h0011);
        wr1(16'h0022);
        settle();
        chk("R6 word ready before reset", rd_flag, 0);
        do_reset(0, 0);
        chk("R10 partial keeps mode rd_flag", rd_flag, 1);
        chk("R10 partial keeps mode wr_flag", wr_flag, 0);
        wr1(16'h0033);
        settle();
        chk("R10 still falls through", rd_flag, 0);
        chk("R10 fresh word after partial", rd_data, 16'h0033);
        do_reset(1, 0);
        chk("R10 master loads std rd_flag", rd_flag, 0);
        chk("R10 master loads std wr_flag", wr_flag, 1);
    endtask

    task automatic t_retransmit();
        for (int i = 0; i < 4; i++) wr1(DW'(16'h50 + i));
        settle();
        @(negedge rclk); rt_hold = 1;
        repeat (2) @(negedge rclk);
        rd1();
        chk("R5 read before mark use", rd_data, 16'h0050);
        rd1();
        chk("R5 second read", rd_data, 16'h0051);
        settle();
        for (int i = 0; i < D - 4; i++) begin
            wr1(DW'(16'h60 + i));
            chk("R8 full against mark", wr_flag, (i == D-5) ? 0 : 1);
        end
        wr1(16'h00EE);
        chk("R8 write blocked under mark", wr_flag, 0);
        @(negedge rclk); rt_rewind = 1;
        @(negedge rclk); rt_rewind = 0;
        for (int i = 0; i < 3; i++) begin
            rd1();
            chk("R9 replay from mark", rd_data, 16'h50 + i);
        end
        @(negedge rclk); rt_hold = 0;
        settle();
        chk("R8 space after release", wr_flag, 1);
    endtask

    initial begin
        repeat (100000) @(posedge wclk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset_std();
        t_std_fill_drain();
        t_lookahead();
        t_reset_modes();
        t_retransmit();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule